// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus that lets an outside controller set and read back the eight control bytes of a clock-synthesizer chip. The chip's system clock samples the bus lines. The block pulls the data line low only through an open-drain enable. It recognises its own 7-bit address and then a command byte. The command byte selects one of two modes. A single-byte access reaches any register by offset. A counted block access always starts at register zero.

Several control bits from the register bank drive the rest of the chip: the output-buffer enable, the spread-spectrum on/off bit, the spread-depth select, and two test controls. The last register is a fixed identity byte. It holds a 4-bit revision in its high nibble and a 4-bit vendor code in its low nibble. The block acknowledges writes to this register but does not store them.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset the registers hold, by index 0 to 7: 7Ch, 00h, 01h, AFh, 01h, 00h, 00h, 01h.
- R2: The slave acknowledges an address byte only when its upper seven bits are 1101001, so D2h is a write and D3h is a read. It leaves any other address byte unacknowledged and ignores the rest of that transfer.
- R3: The command byte is decoded as follows. Bit 7 set selects a byte access. Bit 7 clear selects a block access. Bits 6:5 must be 00. Bits 4:0 give the offset, which must be below 8 for a byte access and must be 0 for a block access. A command that breaks any of these rules is not acknowledged and changes nothing.
- R4: A byte write (D2h, command, data) stores the data byte at the chosen offset. Every byte of it is acknowledged.
- R5: A byte read (D2h, command, repeated START, D3h) returns the register at the chosen offset, most significant bit first.
- R6: A block write (D2h, command 00h, count, data bytes) acknowledges the count and stores the data bytes into registers 0, 1, 2 and so on, in that order.
- R7: A block read (D2h, 00h, repeated START, D3h) first sends the count 08h and then registers 0 to 7 in order. While the controller acknowledges, the slave keeps sending. After a not-acknowledge it releases the bus.
- R8: Register 7 reads as the revision code in bits 7:4 and the vendor code in bits 3:0, which is 01h by default. A write to it is acknowledged and ignored.
- R9: The control outputs decode the registers as follows: out_en = reg0[2], ss_en = reg2[0], ss_sel = reg2[7] (1 means the deeper spread), test_sel = reg6[7] and test_mode = reg6[6].
- R10: The slave recognises START and STOP at any point. Either one ends the transfer in progress. A byte cut short by either one is never stored.
- R11: The slave changes its drive on the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, pull the data line low |
| out_en | output | 1 | Clock output buffer enable |
| ss_en | output | 1 | Spread-spectrum enable |
| ss_sel | output | 1 | Spread depth: 0 shallow, 1 deep |
| test_sel | output | 1 | Test-mode output select |
| test_mode | output | 1 | Test-mode entry |

## Verification
A wrong phase or bit counter in the state machine shows up on the data line within one byte time. The symptom is either a missing or extra acknowledge on the ninth clock, or a read byte shifted by one bit position. A wrong register pointer shows up in the order of the bytes a block read returns. A corrupted register bit shows up on the decoded control pins at once. It also shows up in the next readback of that register. An abort that leaves a stale state makes the next, well-formed transfer go unacknowledged.

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [3:0] REV_CODE    = 4'h0,
  parameter logic [3:0] VENDOR_CODE = 4'h1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe,
  output logic out_en,
  output logic ss_en,
  output logic ss_sel,
  output logic test_sel,
  output logic test_mode
);

  localparam int NREG = 8;
  localparam int NWR  = NREG - 1;
  localparam logic [3:0] PTR_END = 4'(NREG);
  localparam logic [3:0] PTR_WR  = 4'(NWR);
  localparam logic [7:0] BLK_CNT = 8'(NREG);
  localparam logic [NWR*8-1:0] CFG_DEF = {8'h00, 8'h00, 8'h01, 8'hAF, 8'h01, 8'h00, 8'h7C};

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} kind_t;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;
  wire        scl_s = scl_ff[1];
  wire        sda_s = sda_ff[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_in};
      sda_ff <= {sda_ff[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;

  st_t              st;
  kind_t            kind;
  logic [7:0]       sr;
  logic [3:0]       bitcnt;
  logic [3:0]       ptr;
  logic             byte_mode, rd_dir, send_cnt, mack;
  logic [NWR*8-1:0] cfg;

  wire [NREG*8-1:0] all_regs = {REV_CODE, VENDOR_CODE, cfg};
  wire [7:0] rd_byte = (ptr < PTR_END) ? all_regs[{ptr[2:0], 3'b000} +: 8] : 8'hFF;
  wire [7:0] tx_next = send_cnt ? BLK_CNT : rd_byte;
  wire addr_hit = (sr[7:1] == DEV_ADDR);
  wire cmd_ok   = (sr[6:5] == 2'b00) && (sr[7] ? (sr[4:0] < 5'(NREG)) : (sr[4:0] == 5'd0));
  wire byte_end = scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_ADDR;
      sr        <= 8'h00;
      bitcnt    <= 4'd0;
      ptr       <= 4'd0;
      byte_mode <= 1'b0;
      rd_dir    <= 1'b0;
      send_cnt  <= 1'b0;
      mack      <= 1'b0;
      cfg       <= CFG_DEF;
    end else if (start_det) begin
      st     <= S_RX;
      kind   <= K_ADDR;
      bitcnt <= 4'd0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            case (kind)
              K_ADDR: begin
                if (addr_hit) begin
                  st       <= S_ACK;
                  rd_dir   <= sr[0];
                  send_cnt <= ~byte_mode;
                  kind     <= K_CMD;
                end else begin
                  st <= S_IDLE;
                end
              end
              K_CMD: begin
                if (cmd_ok) begin
                  st        <= S_ACK;
                  byte_mode <= sr[7];
                  ptr       <= sr[7] ? sr[3:0] : 4'd0;
                  kind      <= sr[7] ? K_DATA : K_CNT;
                end else begin
                  st <= S_IDLE;
                end
              end
              K_CNT: begin
                st   <= S_ACK;
                kind <= K_DATA;
              end
              default: begin
                if (ptr < PTR_END) begin
                  st <= S_ACK;
                  if (ptr < PTR_WR) cfg[{ptr[2:0], 3'b000} +: 8] <= sr;
                  ptr <= byte_mode ? PTR_END : ptr + 4'd1;
                end else begin
                  st <= S_IDLE;
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= 4'd0;
            if (rd_dir) begin
              st <= S_TX;
              sr <= tx_next;
              if (send_cnt) send_cnt <= 1'b0;
              else if (ptr < PTR_END) ptr <= ptr + 4'd1;
            end else begin
              st <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st <= S_MACK;
            end else begin
              sr     <= {sr[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st     <= S_TX;
              bitcnt <= 4'd0;
              sr     <= tx_next;
              if (send_cnt) send_cnt <= 1'b0;
              else if (ptr < PTR_END) ptr <= ptr + 4'd1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe    = (st == S_ACK) | ((st == S_TX) & ~sr[7]);
  assign out_en    = cfg[2];
  assign ss_en     = cfg[16];
  assign ss_sel    = cfg[23];
  assign test_sel  = cfg[55];
  assign test_mode = cfg[54];

  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_foreign_addr_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && kind == K_ADDR && byte_end && !start_det && !stop_det && !addr_hit) |=> !sda_oe);

  assert_bad_cs_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && kind == K_CMD && byte_end && !start_det && !stop_det && sr[6:5] != 2'b00) |=> !sda_oe);

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_idle_holds_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> $stable(cfg));

endmodule

// File: tb/cfg_smbus_slave_bench.sv
module cfg_smbus_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, out_en, ss_en, ss_sel, test_sel, test_mode;
  logic sda_line;
  int total = 0;
  int bad = 0;
  int viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_r [0:7];

  always #10 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  cfg_smbus_slave u_cfg_smbus_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .out_en(out_en), .ss_en(ss_en), .ss_sel(ss_sel), .test_sel(test_sel), .test_mode(test_mode)
  );

  always @(negedge clk) begin
    if (sda_oe != prev_oe && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic b_stop();
    m_low = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); b = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv(input logic ack_it, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~ack_it);
  endtask

  task automatic byte_write(input logic [7:0] off, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    b_start(); send(8'hD2, a1); send(8'h80 | off, a2); send(d, a3); b_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic byte_read(input logic [7:0] off, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    b_start(); send(8'hD2, a1); send(8'h80 | off, a2);
    b_start(); send(8'hD3, a3); recv(1'b0, d); b_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic block_read_check(input string req);
    logic a1, a2, a3;
    logic [7:0] d;
    b_start(); send(8'hD2, a1); send(8'h00, a2);
    b_start(); send(8'hD3, a3);
    chk({req, " block read acks"}, {a1, a2, a3}, 3'b111);
    recv(1'b1, d);
    chk({req, " R7 count byte"}, d, 8'h08);
    for (int i = 0; i < 8; i++) begin
      recv(i != 7, d);
      chk($sformatf("%s R7 reg%0d", req, i), d, exp_r[i]);
    end
    b_stop();
    chk({req, " R7 released after nack"}, sda_oe, 1'b0);
  endtask

  task automatic check_pins(input string req);
    chk({req, " R9 out_en"}, out_en, exp_r[0][2]);
    chk({req, " R9 ss_en"}, ss_en, exp_r[2][0]);
    chk({req, " R9 ss_sel"}, ss_sel, exp_r[2][7]);
    chk({req, " R9 test_sel"}, test_sel, exp_r[6][7]);
    chk({req, " R9 test_mode"}, test_mode, exp_r[6][6]);
  endtask

  task automatic t_reset();
    chk("R1 no drive after reset", sda_oe, 1'b0);
    check_pins("R1 reset");
    block_read_check("R1 R8 defaults");
  endtask

  task automatic t_bad_addr();
    logic a;
    b_start(); send(8'hD4, a); b_stop();
    chk("R2 foreign address nacked", a, 1'b0);
    b_start(); send(8'h52, a); b_stop();
    chk("R2 other address nacked", a, 1'b0);
    b_start(); send(8'hD2, a); b_stop();
    chk("R2 own address acked", a, 1'b1);
  endtask

  task automatic t_byte_rw();
    logic ok;
    logic [7:0] d;
    byte_write(8'd0, 8'h00, ok); exp_r[0] = 8'h00;
    chk("R4 byte write acks", ok, 1'b1);
    check_pins("R4 reg0 cleared");
    byte_read(8'd0, d, ok);
    chk("R5 byte read reg0", {ok, d}, {1'b1, 8'h00});
    byte_write(8'd5, 8'hA5, ok); exp_r[5] = 8'hA5;
    byte_read(8'd5, d, ok);
    chk("R5 byte read reg5 msb first", {ok, d}, {1'b1, 8'hA5});
    byte_read(8'd3, d, ok);
    chk("R5 byte read reg3", {ok, d}, {1'b1, 8'hAF});
  endtask

  task automatic t_fields();
    logic ok;
    byte_write(8'd2, 8'h80, ok); exp_r[2] = 8'h80;
    byte_write(8'd6, 8'hC0, ok); exp_r[6] = 8'hC0;
    check_pins("R9 fields set");
    byte_write(8'd6, 8'h40, ok); exp_r[6] = 8'h40;
    byte_write(8'd0, 8'h04, ok); exp_r[0] = 8'h04;
    check_pins("R9 fields mixed");
  endtask

  task automatic t_reg7();
    logic ok;
    logic [7:0] d;
    byte_write(8'd7, 8'h55, ok);
    chk("R8 write to reg7 acked", ok, 1'b1);
    byte_read(8'd7, d, ok);
    chk("R8 reg7 unchanged", d, 8'h01);
  endtask

  task automatic t_bad_cmd();
    logic a1, a2, a3;
    b_start(); send(8'hD2, a1); send(8'hA1, a2); send(8'hFF, a3); b_stop();
    chk("R3 chip-select field nonzero nacked", a2, 1'b0);
    chk("R3 data after bad command ignored", a3, 1'b0);
    b_start(); send(8'hD2, a1); send(8'h88, a2); b_stop();
    chk("R3 byte offset 8 nacked", a2, 1'b0);
    b_start(); send(8'hD2, a1); send(8'h03, a2); send(8'h01, a3); send(8'hFF, a3); b_stop();
    chk("R3 block with offset nacked", a2, 1'b0);
    check_pins("R3 nothing changed");
    block_read_check("R3 regs intact");
  endtask

  task automatic t_block();
    logic a1, a2, a3, a4, a5, a6;
    b_start(); send(8'hD2, a1); send(8'h00, a2); send(8'h03, a3);
    send(8'h11, a4); send(8'h22, a5); send(8'h33, a6); b_stop();
    chk("R6 block write all acked", {a1, a2, a3, a4, a5, a6}, 6'b111111);
    exp_r[0] = 8'h11; exp_r[1] = 8'h22; exp_r[2] = 8'h33;
    check_pins("R6 block write");
    block_read_check("R6 block readback");
  endtask

  task automatic t_abort();
    logic a1, a2;
    logic ok;
    logic [7:0] d;
    b_start(); send(8'hD2, a1); send(8'h84, a2);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    b_stop();
    byte_read(8'd4, d, ok);
    chk("R10 stop mid-byte no write", {ok, d}, {1'b1, 8'h01});
    b_start(); send(8'hD2, a1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    b_start(); send(8'hD2, a1); send(8'h84, a2); send(8'h3C, ok); b_stop();
    exp_r[4] = 8'h3C;
    chk("R10 restart mid-command recovers", {a1, a2, ok}, 3'b111);
    byte_read(8'd4, d, ok);
    chk("R10 write after restart stored", d, 8'h3C);
  endtask

  initial begin
    exp_r[0] = 8'h7C; exp_r[1] = 8'h00; exp_r[2] = 8'h01; exp_r[3] = 8'hAF;
    exp_r[4] = 8'h01; exp_r[5] = 8'h00; exp_r[6] = 8'h00; exp_r[7] = 8'h01;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_bad_addr();
    t_byte_rw();
    t_fields();
    t_reg7();
    t_bad_cmd();
    t_block();
    t_abort();
    chk("R11 drive changes only with clock low", viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule